// File: doc/BRIEF.md
# Transmit Jabber Lockout Timer

This block sits on the transmit path of a repeater port and keeps it from sending without end. The repeater core raises a transmit request. On every bit time the block passes that request through to a registered, gated transmit enable. It also counts how many bit times in a row the transmitter has been on. If the request is still present once the run has reached 65,536 bit times, the block turns the transmitter off. It holds it off for a quiet interval of 96 bit times and raises a jabber flag for that whole interval.

When the quiet interval ends, the block releases the transmitter by itself; no outside action is needed. A single bit time with the request low clears the running count, so the block measures only unbroken transmission and never total traffic. All timing advances on the one-bit-time clock enable, so the fabric clock may run faster than the line bit rate.

Top module: `jabber_guard`

## Requirements
- R1: After synchronous reset `tx_en` and `jabber` are low, and both the run count and the quiet count are cleared.
- R2: On each clock where `bit_en` is high and no lockout is in force, `tx_en` takes the value of `tx_req` on the next clock.
- R3: On clocks where `bit_en` is low, `tx_en`, `jabber` and all counts hold their values, whatever `tx_req` does.
- R4: Once `tx_en` has been high for 65,536 consecutive enabled bit times, the next enabled bit time with `tx_req` high drives `tx_en` low and `jabber` high.
- R5: During the lockout `tx_en` stays low even while `tx_req` stays high, and `jabber` stays high for exactly 96 enabled bit times.
- R6: When the quiet interval ends, `jabber` falls and `tx_en` follows `tx_req` again at once, with no outside action. The run count restarts, and that first released bit time counts as one.
- R7: A single enabled bit time with `tx_req` low clears the run count, so a transmission broken by such a gap does not trigger a lockout until it again runs more than 65,536 bit times after the gap.
- R8: `jabber` and `tx_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-bit-time clock enable |
| tx_req | input | 1 | Transmit-active request from the repeater core |
| tx_en | output | 1 | Gated, registered transmit enable |
| jabber | output | 1 | High for the whole of a lockout quiet interval |

## Verification
On every cycle the assertions check the following. The two outputs are mutually exclusive. Both outputs stay frozen on clocks without a bit enable. A lockout is only ever entered from an active transmission. The run of `tx_en` never exceeds 65,536 bit times, and the run of `jabber` never exceeds 96 bit times, each measured by a counter in the checker. Only the bench scenarios can show the exact bit time on which the enable drops, and that the quiet interval lasts exactly 96 bit times with idle clocks in between. They also show that release needs no outside action, and that a one-bit gap in the request pushes the lockout point back by a full limit.

// File: rtl/jab_pkg.sv
package jab_pkg;
  // Default run limit in bit times; a run longer than this triggers lockout.
  localparam int unsigned DEF_LIMIT = 65536;
  // Default quiet interval in bit times.
  localparam int unsigned DEF_QUIET = 96;
endpackage

// File: rtl/jab_run_counter.sv
// Counts consecutive enabled bit times with the gated transmitter on.
module jab_run_counter #(
  parameter int unsigned LIMIT = jab_pkg::DEF_LIMIT,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic req,
  input  logic locked,
  input  logic release_now,
  output logic at_limit
);
  logic [CW-1:0] run_q;

  assign at_limit = (run_q == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (tick) begin
      if (locked) begin
        // The released bit already counts when the request is present.
        run_q <= (release_now && req) ? CW'(1) : '0;
      end else if (!req || at_limit) begin
        run_q <= '0;
      end else begin
        run_q <= run_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/jab_quiet_timer.sv
// Holds the lockout state and times the quiet interval.
module jab_quiet_timer #(
  parameter int unsigned QUIET = jab_pkg::DEF_QUIET,
  localparam int unsigned QW = $clog2(QUIET + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic locked,
  output logic release_now
);
  logic [QW-1:0] quiet_q;

  assign release_now = locked && tick && (quiet_q == QW'(QUIET - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      quiet_q <= '0;
    end else if (tick) begin
      if (start) begin
        locked  <= 1'b1;
        quiet_q <= '0;
      end else if (release_now) begin
        locked  <= 1'b0;
        quiet_q <= '0;
      end else if (locked) begin
        quiet_q <= quiet_q + QW'(1);
      end
    end
  end
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard #(
  parameter int unsigned LIMIT = jab_pkg::DEF_LIMIT,
  parameter int unsigned QUIET = jab_pkg::DEF_QUIET
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic tx_req,
  output logic tx_en,
  output logic jabber
);
  logic at_limit;
  logic locked;
  logic release_now;
  logic start;
  logic lock_nxt;

  assign start    = bit_en && !locked && tx_req && at_limit;
  assign lock_nxt = start || (locked && !release_now);

  jab_run_counter #(.LIMIT(LIMIT)) u_run (
    .clk         (clk),
    .rst         (rst),
    .tick        (bit_en),
    .req         (tx_req),
    .locked      (locked),
    .release_now (release_now),
    .at_limit    (at_limit)
  );

  jab_quiet_timer #(.QUIET(QUIET)) u_quiet (
    .clk         (clk),
    .rst         (rst),
    .tick        (bit_en),
    .start       (start),
    .locked      (locked),
    .release_now (release_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en <= 1'b0;
    end else if (bit_en) begin
      tx_en <= tx_req && !lock_nxt;
    end
  end

  assign jabber = locked;
endmodule

// File: rtl/jabber_guard_chk.sv
module jabber_guard_chk #(
  parameter int unsigned LIMIT = jab_pkg::DEF_LIMIT,
  parameter int unsigned QUIET = jab_pkg::DEF_QUIET
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic tx_req,
  input logic tx_en,
  input logic jabber
);
  logic        prev_tick;
  logic [31:0] on_run;
  logic [31:0] off_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_tick <= 1'b0;
      on_run    <= '0;
      off_run   <= '0;
    end else begin
      prev_tick <= bit_en;
      if (prev_tick) begin
        on_run  <= tx_en  ? on_run + 32'd1  : '0;
        off_run <= jabber ? off_run + 32'd1 : '0;
      end
    end
  end

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(tx_en && jabber)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !bit_en |=> ($stable(tx_en) && $stable(jabber))); // R3
  AST_LOCK_FROM_TX: assert property (@(posedge clk) disable iff (rst) $rose(jabber) |-> $past(tx_en)); // R4
  AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) $rose(tx_en) |-> $past(tx_req)); // R2
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst) on_run <= LIMIT); // R4
  AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (rst) off_run <= QUIET); // R5
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst) $fell(jabber) |-> $past(bit_en)); // R6
endmodule

bind jabber_guard jabber_guard_chk #(.LIMIT(LIMIT), .QUIET(QUIET)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .bit_en (bit_en),
  .tx_req (tx_req),
  .tx_en  (tx_en),
  .jabber (jabber)
);

// File: tb/sim_jabber_guard.sv
`timescale 1ns/1ps
module sim_jabber_guard;
  localparam int unsigned LIMIT = 65536;
  localparam int unsigned QUIET = 96;
  localparam int NVEC = 9;
  // {tx_req, bit_en, expected tx_en, expected jabber}
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1110, 4'b0010, 4'b0100, 4'b1000, 4'b1110,
    4'b0100, 4'b1110, 4'b1010, 4'b0100
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic tx_req = 1'b0;
  logic tx_en, jabber;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  jabber_guard #(.LIMIT(LIMIT), .QUIET(QUIET)) u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_req(tx_req),
    .tx_en(tx_en), .jabber(jabber)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {tx_en,jabber} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e);
    @(negedge clk);
    tx_req = r;
    bit_en = e;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tx_req = 1'b1; bit_en = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0; tx_req = 1'b0; bit_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    int qbits;
    // R1: reset state
    @(posedge clk); #1;
    check("R1 reset", {tx_en, jabber}, 2'b00);
    do_reset();
    #1;
    check("R1 after reset", {tx_en, jabber}, 2'b00);

    // R2, R3: vector walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][3], VEC[i][2]);
      check(VEC[i][2] ? "R2 follow" : "R3 hold", {tx_en, jabber}, VEC[i][1:0]);
    end

    // R1: reset in the middle of a transmission
    step(1'b1, 1'b1);
    do_reset();
    #1;
    check("R1 reset mid-run", {tx_en, jabber}, 2'b00);

    // R4: full continuous run up to the limit
    bad = 0;
    for (int i = 0; i < LIMIT; i++) begin
      step(1'b1, 1'b1);
      if (tx_en !== 1'b1 || jabber !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R4 run: bad bits actual=%0d expected=0", bad);
    end
    step(1'b1, 1'b1);
    check("R4 lock on limit+1", {tx_en, jabber}, 2'b01);

    // R5: quiet length, with idle clocks inside; R3 hold during quiet
    qbits = 1;
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      if (i == 40) begin
        for (int k = 0; k < 20; k++) step(1'b1, 1'b0);
        check("R3 quiet hold", {tx_en, jabber}, 2'b01);
      end
      step(1'b1, 1'b1);
      if (!jabber) break;
      qbits++;
      if (tx_en !== 1'b0) bad++;
    end
    checks++;
    if (qbits != QUIET) begin
      errors++;
      $display("FAIL R5 quiet length actual=%0d expected=%0d", qbits, QUIET);
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R5 tx during quiet actual=%0d expected=0", bad);
    end
    // R6: released bit
    check("R6 release", {tx_en, jabber}, 2'b10);

    // R7: a run broken by one idle bit
    for (int i = 0; i < 1000; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    check("R7 gap bit", {tx_en, jabber}, 2'b00);
    bad = 0;
    for (int i = 0; i < LIMIT; i++) begin
      step(1'b1, 1'b1);
      if (tx_en !== 1'b1 || jabber !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL R7 no early lock: bad bits actual=%0d expected=0", bad);
    end
    step(1'b1, 1'b1);
    check("R7 R4 lock after gap", {tx_en, jabber}, 2'b01);
    // R5: request drop during quiet does not release early
    step(1'b0, 1'b1);
    check("R5 quiet ignores req", {tx_en, jabber}, 2'b01);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule